// File: doc/BRIEF.md
# Pipeline Hazard Stall Unit

This unit decides, every cycle, whether the instruction waiting in decode of an in-order five-stage pipeline may move on to execute. Next to the execute stage sits a pipelined multiplier of parameterized depth. The pipeline forwards results from every stage that has them, so this unit only holds decode back for hazards that forwarding cannot cover:
- a load whose data is needed by the very next instruction;
- a multiply whose product is not yet ready;
- two instructions that would reach the single register-file write port in the same cycle;
- a short-latency write that would overtake an older multiply aimed at the same register.

Its inputs are the decoded fields already held in the pipeline latches. These are the decode instruction's sources, destination and class; the class, destination and valid flag of the execute-input latch; and the destinations held in the multiplier's internal stage latches. Its outputs are combinational enables for the PC and the decode latch, plus clear controls that turn latch contents into nops.

The unit also keeps one registered bit that says whether the execute-input latch holds a real instruction or an injected nop. Comparisons against that latch are ignored while it holds a nop. A flush request overrides any stall.

Top module: `hz_stall_unit`

## Requirements
- R1: After reset `dx_live` is 0, and with a nop in decode the unit reports no stall: `pc_we`=1, `fd_we`=1, `fd_clr`=0, `dx_clr`=0.
- R2: When `dx_live`=1, `dx_cls` is the load code 1, `dx_rd_vld`=1, `dx_rd` is nonzero and `fd_rs1` equals `dx_rd`, the unit stalls. Class codes are: ALU 0, load 1, store 2, multiply 3, branch 4, nop 7.
- R3: The same load case with a match on `fd_rs2` stalls, except when `fd_cls` is the store code 2. A store's data operand is forwarded later, so it needs no stall.
- R4: A multiply stage is a position holding a multiply with a valid, nonzero destination. Stage 0 is the execute-input latch holding class 3 with `dx_live`=1; stage k≥1 is internal latch k-1 (`mul_vld`/`mul_rd`, RW bits per entry, entry 0 in the low bits). Any decode source matching stage 0 to MUL_DEPTH-2 stalls. The last multiply stage is forwarded and never stalls, so a multiply followed at once by a dependent instruction costs MUL_DEPTH-1 stall cycles (3 by default).
- R5: A decode instruction with a valid nonzero destination that is not a multiply stalls while stage MUL_DEPTH-3 is occupied, because both would write the register file in the same cycle.
- R6: A non-multiply decode instruction whose valid nonzero destination equals the destination in stages 0 to MUL_DEPTH-3 stalls; a multiply followed at once by such a write costs 2 stall cycles by default.
- R7: Register 0 and invalid destinations never cause a stall, and a nop in decode (`fd_cls`=7) never stalls.
- R8: While stalling without a flush, `pc_we`=0, `fd_we`=0, `fd_clr`=0 and `dx_clr`=1.
- R9: `flush`=1 gives `pc_we`=1, `fd_we`=1, `fd_clr`=1 and `dx_clr`=1 regardless of any hazard.
- R10: `dx_live` becomes 1 after an edge where a non-nop advanced, and 0 after an edge with `dx_clr`=1. While it is 0, the execute-input latch fields cause no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Squash decode and execute-input latches |
| fd_cls | input | 3 | Class of the decode instruction |
| fd_rs1 | input | RW | First source register of the decode instruction |
| fd_rs2 | input | RW | Second source register of the decode instruction |
| fd_rd | input | RW | Destination of the decode instruction |
| fd_rd_vld | input | 1 | Decode instruction writes a register |
| dx_cls | input | 3 | Class in the execute-input latch |
| dx_rd | input | RW | Destination in the execute-input latch |
| dx_rd_vld | input | 1 | Execute-input latch instruction writes a register |
| mul_vld | input | MUL_DEPTH-2 | Valid flags of internal multiplier latches |
| mul_rd | input | (MUL_DEPTH-2)*RW | Destinations of internal multiplier latches |
| pc_we | output | 1 | PC write enable |
| fd_we | output | 1 | Decode latch load enable |
| fd_clr | output | 1 | Load a nop into the decode latch |
| dx_clr | output | 1 | Load a nop into the execute-input latch |
| dx_live | output | 1 | Execute-input latch holds a real instruction |

## Verification
The hardest situations to reach are the ones where a multiply moves through its stages while the dependent instruction waits in decode. Each stall decision there depends on where the multiply has got to, so fixed input vectors cannot show the cost of a whole sequence. The bench therefore wraps the unit in a small model of the decode latch, the execute-input latch and the multiplier latches, which advances under the unit's own enables. It runs short instruction sequences through this model and compares the stall totals with the counts worked out from pipeline timing. These sequences include a dependent use two slots after a multiply, which lands exactly on the last stage that still stalls.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [2:0] {
    CLS_ALU    = 3'd0,
    CLS_LOAD   = 3'd1,
    CLS_STORE  = 3'd2,
    CLS_MUL    = 3'd3,
    CLS_BRANCH = 3'd4,
    CLS_NOP    = 3'd7
  } op_cls_e;
endpackage

// File: rtl/hz_loaduse.sv
module hz_loaduse
  import hz_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          dx_live,
  input  logic [2:0]    dx_cls,
  input  logic [RW-1:0] dx_rd,
  input  logic          dx_rd_vld,
  input  logic [2:0]    fd_cls,
  input  logic [RW-1:0] fd_rs1,
  input  logic [RW-1:0] fd_rs2,
  output logic          hit
);
  logic load_prod;
  logic m1, m2;

  assign load_prod = dx_live && (dx_cls == CLS_LOAD) && dx_rd_vld && (dx_rd != '0);
  assign m1 = (fd_rs1 == dx_rd);
  // store data operand is forwarded at the memory stage, no stall needed
  assign m2 = (fd_rs2 == dx_rd) && (fd_cls != CLS_STORE);
  assign hit = load_prod && (m1 || m2);
endmodule

// File: rtl/hz_mul_rules.sv
module hz_mul_rules
  import hz_pkg::*;
#(
  parameter int RW        = 5,
  parameter int MUL_DEPTH = 4
) (
  input  logic [MUL_DEPTH-2:0]      stg_vld,
  input  logic [(MUL_DEPTH-1)*RW-1:0] stg_rd,
  input  logic [2:0]                fd_cls,
  input  logic [RW-1:0]             fd_rs1,
  input  logic [RW-1:0]             fd_rs2,
  input  logic [RW-1:0]             fd_rd,
  input  logic                      fd_rd_vld,
  output logic                      src_hit,
  output logic                      port_hit,
  output logic                      order_hit
);
  localparam int NSTG       = MUL_DEPTH - 1;
  localparam int PORT_STAGE = MUL_DEPTH - 3;
  localparam int ORDER_LAST = MUL_DEPTH - 3;

  logic [NSTG-1:0] src_v, port_v, ord_v;
  logic            fd_short_wr;

  assign fd_short_wr = fd_rd_vld && (fd_rd != '0) && (fd_cls != CLS_MUL);

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    logic [RW-1:0] rd_k;
    logic          act_k;
    assign rd_k  = stg_rd[k*RW +: RW];
    assign act_k = stg_vld[k] && (rd_k != '0);
    assign src_v[k] = act_k && ((fd_rs1 == rd_k) || (fd_rs2 == rd_k));
    if (k == PORT_STAGE) begin : g_port
      assign port_v[k] = act_k;
    end else begin : g_noport
      assign port_v[k] = 1'b0;
    end
    if (k <= ORDER_LAST) begin : g_ord
      assign ord_v[k] = act_k && (fd_rd == rd_k);
    end else begin : g_noord
      assign ord_v[k] = 1'b0;
    end
  end

  assign src_hit   = |src_v;
  assign port_hit  = fd_short_wr && (|port_v);
  assign order_hit = fd_short_wr && (|ord_v);
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import hz_pkg::*;
#(
  parameter int RW        = 5,
  parameter int MUL_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic [2:0]                  fd_cls,
  input  logic [RW-1:0]               fd_rs1,
  input  logic [RW-1:0]               fd_rs2,
  input  logic [RW-1:0]               fd_rd,
  input  logic                        fd_rd_vld,
  input  logic [2:0]                  dx_cls,
  input  logic [RW-1:0]               dx_rd,
  input  logic                        dx_rd_vld,
  input  logic [MUL_DEPTH-3:0]        mul_vld,
  input  logic [(MUL_DEPTH-2)*RW-1:0] mul_rd,
  output logic                        pc_we,
  output logic                        fd_we,
  output logic                        fd_clr,
  output logic                        dx_clr,
  output logic                        dx_live
);
  localparam int NSTG = MUL_DEPTH - 1;

  logic               fd_live;
  logic [NSTG-1:0]    stg_vld;
  logic [NSTG*RW-1:0] stg_rd;
  logic               lu_hit, src_hit, port_hit, order_hit;
  logic               stall;

  assign fd_live = (fd_cls != CLS_NOP);

  // stage 0 is the multiply sitting in the execute-input latch
  assign stg_vld[0]         = dx_live && (dx_cls == CLS_MUL) && dx_rd_vld;
  assign stg_rd[RW-1:0]     = dx_rd;
  assign stg_vld[NSTG-1:1]  = mul_vld;
  assign stg_rd[NSTG*RW-1:RW] = mul_rd;

  hz_loaduse #(.RW(RW)) u_lu (
    .dx_live   (dx_live),
    .dx_cls    (dx_cls),
    .dx_rd     (dx_rd),
    .dx_rd_vld (dx_rd_vld),
    .fd_cls    (fd_cls),
    .fd_rs1    (fd_rs1),
    .fd_rs2    (fd_rs2),
    .hit       (lu_hit)
  );

  hz_mul_rules #(.RW(RW), .MUL_DEPTH(MUL_DEPTH)) u_mr (
    .stg_vld   (stg_vld),
    .stg_rd    (stg_rd),
    .fd_cls    (fd_cls),
    .fd_rs1    (fd_rs1),
    .fd_rs2    (fd_rs2),
    .fd_rd     (fd_rd),
    .fd_rd_vld (fd_rd_vld),
    .src_hit   (src_hit),
    .port_hit  (port_hit),
    .order_hit (order_hit)
  );

  assign stall = fd_live && (lu_hit || src_hit || port_hit || order_hit);

  always_comb begin
    if (flush) begin
      pc_we  = 1'b1;
      fd_we  = 1'b1;
      fd_clr = 1'b1;
      dx_clr = 1'b1;
    end else if (stall) begin
      pc_we  = 1'b0;
      fd_we  = 1'b0;
      fd_clr = 1'b0;
      dx_clr = 1'b1;
    end else begin
      pc_we  = 1'b1;
      fd_we  = 1'b1;
      fd_clr = 1'b0;
      dx_clr = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dx_live <= 1'b0;
    else     dx_live <= !dx_clr && fd_live;
  end
endmodule

// File: rtl/hz_stall_unit_chk.sv
module hz_stall_unit_chk
  import hz_pkg::*;
#(
  parameter int RW        = 5,
  parameter int MUL_DEPTH = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        flush,
  input logic [2:0]                  fd_cls,
  input logic [RW-1:0]               fd_rs1,
  input logic [2:0]                  dx_cls,
  input logic [RW-1:0]               dx_rd,
  input logic                        dx_rd_vld,
  input logic [MUL_DEPTH-3:0]        mul_vld,
  input logic [(MUL_DEPTH-2)*RW-1:0] mul_rd,
  input logic                        pc_we,
  input logic                        fd_we,
  input logic                        fd_clr,
  input logic                        dx_clr,
  input logic                        dx_live
);
  a_r8_stall_holds_front: assert property (@(posedge clk) disable iff (rst)
    (!flush && !pc_we) |-> (!fd_we && dx_clr && !fd_clr));

  a_r9_flush_wins: assert property (@(posedge clk) disable iff (rst)
    flush |-> (pc_we && fd_we && fd_clr && dx_clr));

  a_r10_bubble_kills_live: assert property (@(posedge clk) disable iff (rst)
    dx_clr |=> !dx_live);

  a_r10_advance_sets_live: assert property (@(posedge clk) disable iff (rst)
    (!dx_clr && fd_cls != CLS_NOP) |=> dx_live);

  a_r2_load_use_stalls: assert property (@(posedge clk) disable iff (rst)
    (!flush && dx_live && dx_cls == CLS_LOAD && dx_rd_vld && dx_rd != '0 &&
     fd_cls != CLS_NOP && fd_rs1 == dx_rd) |-> !pc_we);

  a_r4_mul_src_stalls: assert property (@(posedge clk) disable iff (rst)
    (!flush && mul_vld[0] && mul_rd[RW-1:0] != '0 && fd_cls != CLS_NOP &&
     fd_rs1 == mul_rd[RW-1:0]) |-> !pc_we);

  a_r7_nop_never_stalls: assert property (@(posedge clk) disable iff (rst)
    (!flush && fd_cls == CLS_NOP) |-> pc_we);
endmodule

bind hz_stall_unit hz_stall_unit_chk #(.RW(RW), .MUL_DEPTH(MUL_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .fd_cls(fd_cls), .fd_rs1(fd_rs1),
  .dx_cls(dx_cls), .dx_rd(dx_rd), .dx_rd_vld(dx_rd_vld),
  .mul_vld(mul_vld), .mul_rd(mul_rd),
  .pc_we(pc_we), .fd_we(fd_we), .fd_clr(fd_clr), .dx_clr(dx_clr), .dx_live(dx_live)
);

// File: tb/tb_hz_stall_unit.sv
`timescale 1ns/1ps
module tb_hz_stall_unit;
  import hz_pkg::*;

  localparam int RW   = 5;
  localparam int MD   = 4;
  localparam int NLAT = MD - 2;

  typedef struct packed {
    logic [2:0]    cls;
    logic [RW-1:0] rd;
    logic [RW-1:0] rs1;
    logic [RW-1:0] rs2;
  } ins_t;

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } item_t;

  localparam ins_t NOP_I = '{cls: 3'd7, rd: '0, rs1: '0, rs2: '0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  // DUT inputs
  logic               flush;
  logic [2:0]         fd_cls, dx_cls;
  logic [RW-1:0]      fd_rs1, fd_rs2, fd_rd, dx_rd;
  logic               fd_rd_vld, dx_rd_vld;
  logic [NLAT-1:0]    mul_vld;
  logic [NLAT*RW-1:0] mul_rd;
  logic               pc_we, fd_we, fd_clr, dx_clr, dx_live;

  // direct-mode drive
  logic       d_flush = 1'b0;
  ins_t       d_fd = NOP_I;
  logic       d_fd_vld = 1'b0;
  ins_t       d_dx = NOP_I;
  logic       d_dx_vld = 1'b0;

  // program-mode model
  logic          prog_mode = 1'b0;
  ins_t          prog [16];
  ins_t          m_fd, m_dx;
  logic [NLAT-1:0] m_lat_vld;
  logic [RW-1:0] m_lat_rd [NLAT];
  logic [3:0]    pc;
  int            stall_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t q[$];

  function automatic logic writes(ins_t i);
    return (i.cls == CLS_ALU) || (i.cls == CLS_LOAD) || (i.cls == CLS_MUL);
  endfunction

  function automatic ins_t mk(logic [2:0] c, int rd, int rs1, int rs2);
    ins_t i;
    i.cls = c; i.rd = RW'(rd); i.rs1 = RW'(rs1); i.rs2 = RW'(rs2);
    return i;
  endfunction

  always_comb begin
    if (prog_mode) begin
      flush     = 1'b0;
      fd_cls    = m_fd.cls;  fd_rs1 = m_fd.rs1; fd_rs2 = m_fd.rs2;
      fd_rd     = m_fd.rd;   fd_rd_vld = writes(m_fd);
      dx_cls    = m_dx.cls;  dx_rd = m_dx.rd;   dx_rd_vld = writes(m_dx);
      mul_vld   = m_lat_vld;
      for (int j = 0; j < NLAT; j++) mul_rd[j*RW +: RW] = m_lat_rd[j];
    end else begin
      flush     = d_flush;
      fd_cls    = d_fd.cls;  fd_rs1 = d_fd.rs1; fd_rs2 = d_fd.rs2;
      fd_rd     = d_fd.rd;   fd_rd_vld = d_fd_vld;
      dx_cls    = d_dx.cls;  dx_rd = d_dx.rd;   dx_rd_vld = d_dx_vld;
      mul_vld   = '0;
      mul_rd    = '0;
    end
  end

  hz_stall_unit #(.RW(RW), .MUL_DEPTH(MD)) dut (
    .clk(clk), .rst(rst), .flush(flush),
    .fd_cls(fd_cls), .fd_rs1(fd_rs1), .fd_rs2(fd_rs2), .fd_rd(fd_rd), .fd_rd_vld(fd_rd_vld),
    .dx_cls(dx_cls), .dx_rd(dx_rd), .dx_rd_vld(dx_rd_vld),
    .mul_vld(mul_vld), .mul_rd(mul_rd),
    .pc_we(pc_we), .fd_we(fd_we), .fd_clr(fd_clr), .dx_clr(dx_clr), .dx_live(dx_live)
  );

  // pipeline latch model advanced by the unit's own enables
  always @(posedge clk) begin
    if (!prog_mode) begin
      m_fd <= NOP_I; m_dx <= NOP_I; m_lat_vld <= '0; pc <= '0; stall_cnt <= 0;
      for (int j = 0; j < NLAT; j++) m_lat_rd[j] <= '0;
    end else begin
      if (!pc_we) stall_cnt <= stall_cnt + 1;
      m_lat_vld[0] <= (m_dx.cls == CLS_MUL);
      m_lat_rd[0]  <= m_dx.rd;
      for (int j = 1; j < NLAT; j++) begin
        m_lat_vld[j] <= m_lat_vld[j-1];
        m_lat_rd[j]  <= m_lat_rd[j-1];
      end
      m_dx <= dx_clr ? NOP_I : m_fd;
      if (fd_we) m_fd <= fd_clr ? NOP_I : prog[pc];
      if (pc_we) pc <= pc + 4'd1;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (q.size() != 0) begin
      item_t e;
      logic [4:0] got;
      e = q.pop_front();
      got = {pc_we, fd_we, fd_clr, dx_clr, dx_live};
      check(got === e.exp, e.tag, int'(got), int'(e.exp));
    end
  end

  // driver: one vector per cycle; expected = {pc_we,fd_we,fd_clr,dx_clr,dx_live}
  task automatic vec(bit fl, ins_t f, bit fv, ins_t d, bit dv, logic [4:0] exp, string tag);
    item_t e;
    @(negedge clk);
    d_flush = fl; d_fd = f; d_fd_vld = fv; d_dx = d; d_dx_vld = dv;
    e.exp = exp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic run_prog(int exp_stalls, string tag);
    @(negedge clk);
    prog_mode = 1'b1;
    repeat (14) @(posedge clk);
    @(negedge clk);
    check(stall_cnt == exp_stalls, tag, stall_cnt, exp_stalls);
    prog_mode = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) prog[i] = NOP_I;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    ins_t ld3, alu_dep, alu_dep2, alu_free, st_data, alu_r0, ld0;
    for (int i = 0; i < 16; i++) prog[i] = NOP_I;
    ld3      = mk(CLS_LOAD, 3, 2, 0);
    alu_dep  = mk(CLS_ALU, 7, 3, 1);
    alu_dep2 = mk(CLS_ALU, 8, 1, 3);
    alu_free = mk(CLS_ALU, 9, 4, 5);
    st_data  = mk(CLS_STORE, 0, 1, 3);
    alu_r0   = mk(CLS_ALU, 9, 0, 0);
    ld0      = mk(CLS_LOAD, 0, 2, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state, nothing in flight
    vec(0, NOP_I, 0, NOP_I, 0, 5'b11000, "R1 reset state");
    // R10: load in execute latch ignored while not live
    vec(0, alu_dep, 1, ld3, 1, 5'b11000, "R10 dead latch ignored");
    // R2/R8: load-use on source 1
    vec(0, alu_dep, 1, ld3, 1, 5'b00011, "R2 R8 load-use rs1 stall");
    // R10: after bubble the latch is dead again, no stall
    vec(0, alu_dep, 1, ld3, 1, 5'b11000, "R10 live cleared by bubble");
    // R9: flush overrides live load-use hazard
    vec(1, alu_dep, 1, ld3, 1, 5'b11111, "R9 flush priority");
    vec(0, alu_free, 1, ld3, 1, 5'b11000, "R10 no hazard after flush");
    // R3: store data operand exempt
    vec(0, st_data, 0, ld3, 1, 5'b11001, "R3 store rs2 exempt");
    // R3: non-store rs2 match stalls
    vec(0, alu_dep2, 1, ld3, 1, 5'b00011, "R3 load-use rs2 stall");
    vec(0, alu_free, 1, ld3, 1, 5'b11000, "R10 independent advance");
    // R7: register 0 producer never stalls
    vec(0, alu_r0, 1, ld0, 1, 5'b11001, "R7 register 0 no stall");
    @(negedge clk);
    @(negedge clk);

    // R4: multiply then dependent use, 3 stalls
    prog[0] = mk(CLS_MUL, 4, 3, 5); prog[1] = mk(CLS_ALU, 6, 4, 0);
    run_prog(3, "R4 mul dependent stall count");
    // R6: multiply then same-destination write, 2 stalls
    prog[0] = mk(CLS_MUL, 4, 3, 5); prog[1] = mk(CLS_ALU, 4, 1, 0);
    run_prog(2, "R6 write order stall count");
    // R5: second follower would share the write port
    prog[0] = mk(CLS_MUL, 4, 3, 5); prog[1] = mk(CLS_ALU, 6, 1, 0);
    prog[2] = mk(CLS_ALU, 5, 6, 10);
    run_prog(1, "R5 write port stall count");
    // R2: load then dependent add
    prog[0] = mk(CLS_LOAD, 3, 2, 0); prog[1] = mk(CLS_ALU, 4, 2, 3);
    run_prog(1, "R2 load-use stall count");
    // R3: load then store of loaded data
    prog[0] = mk(CLS_LOAD, 3, 2, 0); prog[1] = mk(CLS_STORE, 0, 2, 3);
    run_prog(0, "R3 store data no stall count");
    // R3: load then store addressed by loaded value
    prog[0] = mk(CLS_LOAD, 3, 2, 0); prog[1] = mk(CLS_STORE, 0, 3, 6);
    run_prog(1, "R3 store address stall count");
    // R7: multiply to register 0 and its readers
    prog[0] = mk(CLS_MUL, 0, 3, 5); prog[1] = mk(CLS_ALU, 6, 0, 0);
    prog[2] = mk(CLS_ALU, 5, 0, 0);
    run_prog(0, "R7 register 0 multiply count");
    // R4: dependent use two slots later hits only the last stalling stage
    prog[0] = mk(CLS_MUL, 4, 3, 5); prog[3] = mk(CLS_ALU, 6, 4, 0);
    run_prog(1, "R4 boundary stage stall count");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule